// File: doc/BRIEF.md
# Scalar Negated Multiply-Add Operand Steering and Masked Writeback

This block is the control and writeback shell around a scalar double-precision negated multiply-add core. The core computes `-(a*b) + c` with a single rounding step. A request arrives as an opcode byte, a wide destination register and the low 64-bit elements of a second and a third source. An optional 64-bit memory operand, write-mask controls and rounding controls come with it. The block decodes which of three operand orderings the opcode names. It routes two multiplicands and an addend to the core, picks the rounding mode, and waits for the core's answer. It then merges that 64-bit answer into the destination under the write-mask rules.

Control is a five-state machine. `S_IDLE` waits for `start`. From there the transition *launch* goes to `S_ISSUE` for a legal opcode whose low element will be written. *mask-skip* goes to `S_WRITE` for a legal opcode whose low element is masked off, so the core is never asked. *reject* goes to `S_FAULT` for an unknown opcode. `S_ISSUE` pulses the core request and always moves on (*issued*) to `S_WAIT`. `S_WAIT` stays put until the core reports done (*answered*), then goes to `S_WRITE`. `S_WRITE` presents the merged destination for one cycle, and `S_FAULT` presents the untouched destination with the illegal flag for one cycle. Both return to `S_IDLE` (*retire*).

Operands are latched when `start` is accepted in `S_IDLE`. Requests made while busy are dropped.

Top module: `fnma_wb_unit`

## Requirements
- R1: Opcode 0x9D routes destination bits 63:0 to `core_mul_a`, the third source to `core_mul_b` and the second source to `core_addend`.
- R2: Opcode 0xAD routes the second source to `core_mul_a`, destination bits 63:0 to `core_mul_b` and the third source to `core_addend`.
- R3: Opcode 0xBD routes the second source to `core_mul_a`, the third source to `core_mul_b` and destination bits 63:0 to `core_addend`.
- R4: When `src3_mem` is 1, the 64-bit `mem_op` replaces the third source in every ordering.
- R5: `core_rmode` equals `rc_inst` only when `enc_ext`=1, `rc_ovr`=1 and `src3_mem`=0. Otherwise it equals `rc_ctl`. The codes pass through unchanged: 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R6: With `enc_ext`=1, `mask_on`=1 and `mask_k0`=0, the core is not requested. The written bits 63:0 keep the destination's value when `mask_zero`=0, and are zero when `mask_zero`=1.
- R7: When `enc_ext`=0 (masks ignored), `mask_on`=0, or `mask_k0`=1, the written bits 63:0 equal `core_result`.
- R8: In every legal write, `dest_out` bits 127:64 equal the destination's bits 127:64, and bits VLEN-1:128 are zero.
- R9: An unknown opcode pulses `illegal_op` for one cycle without a core request and without `dest_valid`. During that pulse `dest_out` equals the whole latched destination, unchanged.
- R10: `core_go` is high for exactly the one cycle after `start` is accepted. `dest_valid` rises in the cycle after the edge that samples `core_done` in `S_WAIT`. `start` while `busy` is ignored.
- R11: After reset, `busy`, `core_go`, `dest_valid` and `illegal_op` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, accepted in idle |
| opcode | input | 8 | Opcode byte selecting the operand ordering |
| enc_ext | input | 1 | 1 = extended encoding with masking and rounding override |
| src3_mem | input | 1 | 1 = third source comes from memory |
| rc_ovr | input | 1 | Per-instruction rounding override enable |
| rc_inst | input | 2 | Rounding code carried by the instruction |
| rc_ctl | input | 2 | Rounding code from the global control register |
| mask_on | input | 1 | A write mask is applied |
| mask_k0 | input | 1 | Mask bit 0 |
| mask_zero | input | 1 | 1 = zeroing, 0 = merging for a masked-off element |
| dest_in | input | VLEN | Destination register, also first source |
| src2_in | input | LANE | Low element of second source |
| src3_in | input | LANE | Low element of third source register |
| mem_op | input | LANE | Memory third-source operand |
| core_go | output | 1 | One-cycle request to the arithmetic core |
| core_mul_a | output | LANE | First multiplicand |
| core_mul_b | output | LANE | Second multiplicand |
| core_addend | output | LANE | Addend |
| core_rmode | output | 2 | Rounding code for the core |
| core_done | input | 1 | Core result is valid |
| core_result | input | LANE | Rounded core result |
| dest_out | output | VLEN | Final destination value |
| dest_valid | output | 1 | `dest_out` holds a completed write |
| illegal_op | output | 1 | Unknown opcode was rejected |
| busy | output | 1 | A request is in flight |

## Verification
The three orderings are driven with one fixed set of operands, each lane carrying a distinct pattern. A swapped multiplicand or addend therefore shows up as a wrong value on a named core port. Memory forms are tried with the override bit set, so that both operand replacement and the override being ignored are seen. Masking is tried as merge and as zero with bit 0 clear, as bit 0 set, and with masks presented to a legacy encoding. This separates "skip the core", "write result" and "keep or clear" by the low element of `dest_out`. An unknown opcode and a second `start` sent while busy check that the destination survives intact.

// File: rtl/fnma_pkg.sv
package fnma_pkg;

    localparam logic [7:0] OPC_MUL_DS_ADD_S2 = 8'h9D;
    localparam logic [7:0] OPC_MUL_S2D_ADD_S3 = 8'hAD;
    localparam logic [7:0] OPC_MUL_S2S3_ADD_D = 8'hBD;

    typedef enum logic [1:0] {
        FORM_132,
        FORM_213,
        FORM_231,
        FORM_BAD
    } form_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_WRITE,
        S_FAULT
    } state_e;

    function automatic form_e decode_form(input logic [7:0] op);
        form_e f;
        unique case (op)
            OPC_MUL_DS_ADD_S2:  f = FORM_132;
            OPC_MUL_S2D_ADD_S3: f = FORM_213;
            OPC_MUL_S2S3_ADD_D: f = FORM_231;
            default:            f = FORM_BAD;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/fnma_steer.sv
module fnma_steer
    import fnma_pkg::*;
#(
    parameter int LANE = 64
) (
    input  form_e             form,
    input  logic [LANE-1:0]   dst_lo,
    input  logic [LANE-1:0]   s2_lo,
    input  logic [LANE-1:0]   s3_lo,
    input  logic [LANE-1:0]   mem_lo,
    input  logic              use_mem,
    output logic [LANE-1:0]   mul_a,
    output logic [LANE-1:0]   mul_b,
    output logic [LANE-1:0]   addend
);

    logic [LANE-1:0] third;

    always_comb begin
        third = use_mem ? mem_lo : s3_lo;
        unique case (form)
            FORM_132: begin
                mul_a  = dst_lo;
                mul_b  = third;
                addend = s2_lo;
            end
            FORM_213: begin
                mul_a  = s2_lo;
                mul_b  = dst_lo;
                addend = third;
            end
            FORM_231: begin
                mul_a  = s2_lo;
                mul_b  = third;
                addend = dst_lo;
            end
            default: begin
                mul_a  = '0;
                mul_b  = '0;
                addend = '0;
            end
        endcase
    end

endmodule

// File: rtl/fnma_round_sel.sv
module fnma_round_sel (
    input  logic       enc_ext,
    input  logic       rc_ovr,
    input  logic       use_mem,
    input  logic [1:0] rc_inst,
    input  logic [1:0] rc_ctl,
    output logic [1:0] rmode
);

    logic take_inst;

    always_comb begin
        take_inst = enc_ext && rc_ovr && !use_mem;
        rmode     = take_inst ? rc_inst : rc_ctl;
    end

endmodule

// File: rtl/fnma_merge.sv
module fnma_merge #(
    parameter int VLEN = 256,
    parameter int LANE = 64
) (
    input  logic [VLEN-1:0] dest,
    input  logic [LANE-1:0] res,
    input  logic            wr_low,
    input  logic            zero_low,
    input  logic            keep_all,
    output logic [VLEN-1:0] merged
);

    localparam int NLANES = VLEN / LANE;

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        if (g == 0) begin : g_low
            always_comb begin
                if (keep_all)      merged[LANE-1:0] = dest[LANE-1:0];
                else if (wr_low)   merged[LANE-1:0] = res;
                else if (zero_low) merged[LANE-1:0] = '0;
                else               merged[LANE-1:0] = dest[LANE-1:0];
            end
        end else if (g * LANE < 128) begin : g_keep
            assign merged[g*LANE +: LANE] = dest[g*LANE +: LANE];
        end else begin : g_clear
            assign merged[g*LANE +: LANE] = keep_all ? dest[g*LANE +: LANE] : '0;
        end
    end

endmodule

// File: rtl/fnma_wb_unit.sv
module fnma_wb_unit
    import fnma_pkg::*;
#(
    parameter int VLEN = 256,
    parameter int LANE = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [7:0]      opcode,
    input  logic            enc_ext,
    input  logic            src3_mem,
    input  logic            rc_ovr,
    input  logic [1:0]      rc_inst,
    input  logic [1:0]      rc_ctl,
    input  logic            mask_on,
    input  logic            mask_k0,
    input  logic            mask_zero,
    input  logic [VLEN-1:0] dest_in,
    input  logic [LANE-1:0] src2_in,
    input  logic [LANE-1:0] src3_in,
    input  logic [LANE-1:0] mem_op,
    output logic            core_go,
    output logic [LANE-1:0] core_mul_a,
    output logic [LANE-1:0] core_mul_b,
    output logic [LANE-1:0] core_addend,
    output logic [1:0]      core_rmode,
    input  logic            core_done,
    input  logic [LANE-1:0] core_result,
    output logic [VLEN-1:0] dest_out,
    output logic            dest_valid,
    output logic            illegal_op,
    output logic            busy
);

    state_e state, state_nx;

    form_e           form_in;
    logic            legal_in;
    logic            wr_in;
    logic [LANE-1:0] a_in, b_in, c_in;
    logic [1:0]      rm_in;

    logic [VLEN-1:0] dest_q;
    logic [LANE-1:0] a_q, b_q, c_q, res_q;
    logic [1:0]      rm_q;
    logic            wr_q, zero_q;
    logic [VLEN-1:0] merged;

    assign form_in  = decode_form(opcode);
    assign legal_in = (form_in != FORM_BAD);
    assign wr_in    = !enc_ext || !mask_on || mask_k0;

    fnma_steer #(.LANE(LANE)) i_steer (
        .form    (form_in),
        .dst_lo  (dest_in[LANE-1:0]),
        .s2_lo   (src2_in),
        .s3_lo   (src3_in),
        .mem_lo  (mem_op),
        .use_mem (src3_mem),
        .mul_a   (a_in),
        .mul_b   (b_in),
        .addend  (c_in)
    );

    fnma_round_sel i_rsel (
        .enc_ext (enc_ext),
        .rc_ovr  (rc_ovr),
        .use_mem (src3_mem),
        .rc_inst (rc_inst),
        .rc_ctl  (rc_ctl),
        .rmode   (rm_in)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    if (!legal_in)  state_nx = S_FAULT;
                    else if (wr_in) state_nx = S_ISSUE;
                    else            state_nx = S_WRITE;
                end
            end
            S_ISSUE: state_nx = S_WAIT;
            S_WAIT:  if (core_done) state_nx = S_WRITE;
            S_WRITE: state_nx = S_IDLE;
            S_FAULT: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // request capture and result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dest_q <= '0;
            a_q    <= '0;
            b_q    <= '0;
            c_q    <= '0;
            rm_q   <= '0;
            wr_q   <= 1'b0;
            zero_q <= 1'b0;
            res_q  <= '0;
        end else begin
            if (state == S_IDLE && start) begin
                dest_q <= dest_in;
                a_q    <= a_in;
                b_q    <= b_in;
                c_q    <= c_in;
                rm_q   <= rm_in;
                wr_q   <= wr_in;
                zero_q <= !wr_in && mask_zero;
            end
            if (state == S_WAIT && core_done) res_q <= core_result;
        end
    end

    fnma_merge #(.VLEN(VLEN), .LANE(LANE)) i_merge (
        .dest     (dest_q),
        .res      (res_q),
        .wr_low   (wr_q),
        .zero_low (zero_q),
        .keep_all (state == S_FAULT),
        .merged   (merged)
    );

    // outputs
    always_comb begin
        core_go     = (state == S_ISSUE);
        dest_valid  = (state == S_WRITE);
        illegal_op  = (state == S_FAULT);
        busy        = (state != S_IDLE);
        core_mul_a  = a_q;
        core_mul_b  = b_q;
        core_addend = c_q;
        core_rmode  = rm_q;
        dest_out    = merged;
    end

    p_go_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        core_go |=> !core_go);

    p_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dest_q));

    p_mask_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && legal_in && !wr_in) |=> (dest_valid && !core_go));

    p_upper_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dest_valid |-> (dest_out[127:64] == dest_q[127:64]
                        && (dest_out >> 128) == '0));

    p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> (!core_go && !dest_valid && dest_out == dest_q));

endmodule

// File: tb/test_fnma_wb_unit.sv
module test_fnma_wb_unit;

    localparam int VLEN = 256;
    localparam int LANE = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [7:0]      opcode = 8'h00;
    logic            enc_ext = 1'b0, src3_mem = 1'b0, rc_ovr = 1'b0;
    logic [1:0]      rc_inst = 2'b00, rc_ctl = 2'b00;
    logic            mask_on = 1'b0, mask_k0 = 1'b0, mask_zero = 1'b0;
    logic [VLEN-1:0] dest_in = '0;
    logic [LANE-1:0] src2_in = '0, src3_in = '0, mem_op = '0;
    logic            core_go;
    logic [LANE-1:0] core_mul_a, core_mul_b, core_addend;
    logic [1:0]      core_rmode;
    logic            core_done = 1'b0;
    logic [LANE-1:0] core_result = '0;
    logic [VLEN-1:0] dest_out;
    logic            dest_valid, illegal_op, busy;

    int n_cmp = 0;
    int n_bad = 0;

    localparam logic [VLEN-1:0] D0 =
        256'hEEEE_0000_EEEE_0001_CCCC_0000_CCCC_0001_1111_2222_3333_4444_D1D1_D2D2_D3D3_D4D4;
    localparam logic [VLEN-1:0] D1 =
        256'h9999_8888_7777_6666_5555_4444_3333_2222_0F0F_0F0F_0F0F_0F0F_7070_7070_7070_7070;
    localparam logic [LANE-1:0] S2  = 64'h2222_2222_2A2A_2A2A;
    localparam logic [LANE-1:0] S3  = 64'h3333_3333_3B3B_3B3B;
    localparam logic [LANE-1:0] MEM = 64'h4444_4444_4D4D_4D4D;
    localparam logic [LANE-1:0] RES = 64'hC0DE_F00D_1234_5678;

    always #10 clk = ~clk;

    fnma_wb_unit #(.VLEN(VLEN), .LANE(LANE)) i_fnma_wb_unit (
        .clk, .rst_n, .start, .opcode, .enc_ext, .src3_mem, .rc_ovr,
        .rc_inst, .rc_ctl, .mask_on, .mask_k0, .mask_zero,
        .dest_in, .src2_in, .src3_in, .mem_op,
        .core_go, .core_mul_a, .core_mul_b, .core_addend, .core_rmode,
        .core_done, .core_result,
        .dest_out, .dest_valid, .illegal_op, .busy
    );

    task automatic chk(input string tag, input logic [VLEN-1:0] act,
                       input logic [VLEN-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [VLEN-1:0] written(input logic [VLEN-1:0] d,
                                                input logic [LANE-1:0] lo);
        logic [VLEN-1:0] e;
        e = '0;
        e[127:64] = d[127:64];
        e[63:0]   = lo;
        return e;
    endfunction

    // Runs one request. go_exp: core expected; poke: send a second start while busy.
    task automatic run_op(input string tag, input logic [7:0] op,
                          input logic ext, input logic mem, input logic ovr,
                          input logic [1:0] rci, input logic [1:0] rcc,
                          input logic mon, input logic k0, input logic mz,
                          input logic go_exp, input logic poke,
                          input logic [LANE-1:0] ea, input logic [LANE-1:0] eb,
                          input logic [LANE-1:0] ec, input logic [1:0] erm,
                          input logic [VLEN-1:0] eout);
        @(negedge clk);
        opcode = op; enc_ext = ext; src3_mem = mem; rc_ovr = ovr;
        rc_inst = rci; rc_ctl = rcc; mask_on = mon; mask_k0 = k0; mask_zero = mz;
        dest_in = D0; src2_in = S2; src3_in = S3; mem_op = MEM;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (go_exp) begin
            chk({tag, " R10 go"}, VLEN'(core_go), VLEN'(1'b1));
            chk({tag, " mul_a"}, VLEN'(core_mul_a), VLEN'(ea));
            chk({tag, " mul_b"}, VLEN'(core_mul_b), VLEN'(eb));
            chk({tag, " addend"}, VLEN'(core_addend), VLEN'(ec));
            chk({tag, " R5 rmode"}, VLEN'(core_rmode), VLEN'(erm));
            core_done = 1'b1; core_result = RES;
            if (poke) begin
                start = 1'b1; dest_in = D1; opcode = 8'h00;
            end
            @(negedge clk);
            start = 1'b0;
            chk({tag, " R10 go drop"}, VLEN'(core_go), VLEN'(1'b0));
            chk({tag, " R10 not yet valid"}, VLEN'(dest_valid), VLEN'(1'b0));
            @(negedge clk);
            core_done = 1'b0;
            chk({tag, " valid"}, VLEN'(dest_valid), VLEN'(1'b1));
            chk({tag, " dest_out"}, dest_out, eout);
        end else if (op == 8'h9D || op == 8'hAD || op == 8'hBD) begin
            chk({tag, " R6 no go"}, VLEN'(core_go), VLEN'(1'b0));
            chk({tag, " R6 valid"}, VLEN'(dest_valid), VLEN'(1'b1));
            chk({tag, " dest_out"}, dest_out, eout);
        end else begin
            chk({tag, " R9 flag"}, VLEN'(illegal_op), VLEN'(1'b1));
            chk({tag, " R9 no go/valid"}, VLEN'({core_go, dest_valid}), VLEN'(2'b00));
            chk({tag, " R9 dest kept"}, dest_out, eout);
        end
        @(negedge clk);
        chk({tag, " idle after"}, VLEN'({busy, illegal_op, dest_valid}), VLEN'(3'b000));
    endtask

    task automatic t_reset;
        chk("R11 reset outputs", VLEN'({busy, core_go, dest_valid, illegal_op}), VLEN'(4'b0000));
    endtask

    task automatic t_forms;
        run_op("R1 0x9D", 8'h9D, 1'b0, 1'b0, 1'b0, 2'b11, 2'b00, 1'b0, 1'b0, 1'b0,
               1'b1, 1'b0, D0[63:0], S3, S2, 2'b00, written(D0, RES));
        run_op("R2 0xAD", 8'hAD, 1'b0, 1'b0, 1'b0, 2'b11, 2'b01, 1'b0, 1'b0, 1'b0,
               1'b1, 1'b0, S2, D0[63:0], S3, 2'b01, written(D0, RES));
        run_op("R3 0xBD", 8'hBD, 1'b1, 1'b0, 1'b0, 2'b11, 2'b10, 1'b0, 1'b0, 1'b0,
               1'b1, 1'b0, S2, S3, D0[63:0], 2'b10, written(D0, RES));
    endtask

    task automatic t_mem_forms;
        run_op("R4 mem 0x9D ovr ignored", 8'h9D, 1'b1, 1'b1, 1'b1, 2'b11, 2'b01,
               1'b0, 1'b0, 1'b0, 1'b1, 1'b0, D0[63:0], MEM, S2, 2'b01, written(D0, RES));
        run_op("R4 mem 0xAD", 8'hAD, 1'b1, 1'b1, 1'b0, 2'b00, 2'b10,
               1'b0, 1'b0, 1'b0, 1'b1, 1'b0, S2, D0[63:0], MEM, 2'b10, written(D0, RES));
    endtask

    task automatic t_rounding;
        run_op("R5 override", 8'hBD, 1'b1, 1'b0, 1'b1, 2'b11, 2'b00,
               1'b0, 1'b0, 1'b0, 1'b1, 1'b0, S2, S3, D0[63:0], 2'b11, written(D0, RES));
        run_op("R5 legacy no override", 8'hBD, 1'b0, 1'b0, 1'b1, 2'b01, 2'b10,
               1'b0, 1'b0, 1'b0, 1'b1, 1'b0, S2, S3, D0[63:0], 2'b10, written(D0, RES));
    endtask

    task automatic t_masking;
        run_op("R6 merge", 8'h9D, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00,
               1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, '0, 2'b00, written(D0, D0[63:0]));
        run_op("R6 zero", 8'hAD, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00,
               1'b1, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0, '0, 2'b00, written(D0, '0));
        run_op("R7 k0 set", 8'hAD, 1'b1, 1'b0, 1'b0, 2'b00, 2'b11,
               1'b1, 1'b1, 1'b1, 1'b1, 1'b0, S2, D0[63:0], S3, 2'b11, written(D0, RES));
        run_op("R7 legacy ignores mask", 8'h9D, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00,
               1'b1, 1'b0, 1'b1, 1'b1, 1'b0, D0[63:0], S3, S2, 2'b00, written(D0, RES));
    endtask

    task automatic t_illegal;
        run_op("R9 opcode 0x9C", 8'h9C, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00,
               1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, '0, 2'b00, D0);
    endtask

    task automatic t_busy_ignore;
        run_op("R10 R8 start while busy", 8'hBD, 1'b1, 1'b0, 1'b0, 2'b00, 2'b01,
               1'b0, 1'b0, 1'b0, 1'b1, 1'b1, S2, S3, D0[63:0], 2'b01, written(D0, RES));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_forms();
        t_mem_forms();
        t_rounding();
        t_masking();
        t_illegal();
        t_busy_ignore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule